// File: doc/BRIEF.md
# I2C Slave Port for a 16-bit Register Bank

This block is the serial front end of a bank of 16-bit registers. It watches the two lines of an I2C bus and answers one 7-bit device address. It presents to the user logic an 8-bit register pointer, a one-cycle write strobe that carries a 16-bit word, and a 16-bit read-data input that the user logic fills from the register the pointer selects. The serial lines are brought into the clock domain through a synchronizer. Start and stop conditions are taken from edges of the data line while the clock line is high.

A write transaction always begins with a pointer byte after the address, and it may end there. In that case only the pointer moves. Two further bytes form a word, most-significant byte first, and the word is handed over once both bytes have arrived. A read transaction returns the word at the current pointer, high byte first, and leaves the pointer alone. The pointer keeps its value across any number of reads. Data is driven only by pulling the line low: `sda_oe` high means the line is held low.

Top module: `i2c_reg16_port`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged (SDA held low during the ninth clock). Any other address is not acknowledged, and the port then leaves SDA released, keeps `reg_ptr` unchanged and issues no `wr_stb` until the next start condition.
- R2: In a write (address bit 0 low), the first following byte is acknowledged and loaded into `reg_ptr`. A write that stops after that byte changes only the pointer and issues no `wr_stb`.
- R3: The two bytes after the pointer are each acknowledged. After the second one, `wr_stb` is high for exactly one clock, with `wr_data` = {first byte, second byte} and `reg_ptr` still holding the pointer byte.
- R4: A write that ends with a stop or a start after only one data byte issues no `wr_stb`.
- R5: A byte that follows the second data byte of a write is not acknowledged and causes no further `wr_stb`.
- R6: In a read (address bit 0 high), the port sends `rd_data[15:8]` and then, after a master ACK, `rd_data[7:0]`, each byte MSB first. The whole word is captured when the high byte starts.
- R7: A read never changes `reg_ptr`. Back-to-back reads without a pointer write return the same register.
- R8: After the master sends a NACK for a read byte, or after a stop condition, the port releases SDA and does not drive it again before the next start.
- R9: A start condition in the middle of any transfer releases SDA and begins a new address phase. A pointer write followed by a repeated start and a read returns the newly pointed register.
- R10: After reset `sda_oe` is 0, `wr_stb` is 0 and `reg_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| reg_ptr | output | 8 | Current register pointer |
| wr_stb | output | 1 | One-cycle strobe: write `wr_data` to register `reg_ptr` |
| wr_data | output | 16 | Word received in a write |
| rd_data | input | 16 | Contents of register `reg_ptr`, supplied by user logic |

## Verification
A sweep of pointer values that includes the extremes 0x00 and 0xFF and alternating bit patterns runs a full write and then a read for each value. The written words and the read words differ in every byte, so a swapped byte order, a bit-order error or a stale pointer shows up as a mismatch. Shortened transfers show whether the strobe waits for both bytes and whether a pointer-only write leaves the data path untouched: a stop after the pointer, a stop after one data byte, a repeated start in the middle of a write, and a third data byte. A foreign address followed by more bytes, and a NACK after the high read byte followed by extra clocks, show whether the port keeps off the bus until the next start.

// File: rtl/i2c_reg16_pkg.sv
package i2c_reg16_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGN
  } port_state_e;

  // Address byte: upper seven bits compared with the device address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  // Select the high (lo_sel=0) or low (lo_sel=1) byte of a word
  function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w, input logic lo_sel);
    return lo_sel ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  // Byte counter in a write: 0 addr, 1 pointer, 2 high, 3 low, 4 and up surplus
  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
    return (i >= IDX_W'(4)) ? IDX_W'(4) : i + IDX_W'(1);
  endfunction

endpackage

// File: rtl/i2c_reg16_sync.sv
module i2c_reg16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_reg16_cond.sv
module i2c_reg16_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign ev_rise  = scl_s & ~scl_d;
  assign ev_fall  = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg16_port.sv
module i2c_reg16_port
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [1:0] line_raw, line_s;
  logic       ev_rise, ev_fall, ev_start, ev_stop;
  logic       rd_mode, ack_phase;

  assign line_raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sync
      i2c_reg16_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
      );
    end
  endgenerate

  i2c_reg16_cond u_cond (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  port_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [IDX_W-1:0]  idx;
  logic              rw_q, mack_q, lo_sent;
  logic [BYTE_W-1:0] ptr_q, hi_q;
  logic [WORD_W-1:0] rd_q, wdata_q;
  logic              stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      idx     <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      lo_sent <= 1'b0;
      ptr_q   <= '0;
      hi_q    <= '0;
      rd_q    <= '0;
      wdata_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (ev_stop) begin
        state <= ST_IDLE;
      end else if (ev_start) begin
        state <= ST_RX;
        cnt   <= '0;
        idx   <= '0;
        rw_q  <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (ev_rise) begin
              sh  <= {sh[BYTE_W-2:0], line_s[0]};
              cnt <= cnt + CNT_W'(1);
            end else if (ev_fall && cnt == CNT_W'(BYTE_W)) begin
              cnt <= '0;
              idx <= idx_next(idx);
              if (idx == IDX_W'(0)) begin
                if (addr_hit(sh, DEV_ADDR)) begin
                  rw_q  <= sh[0];
                  state <= ST_ACK;
                end else begin
                  state <= ST_IGN;
                end
              end else if (idx == IDX_W'(1)) begin
                ptr_q <= sh;
                state <= ST_ACK;
              end else if (idx == IDX_W'(2)) begin
                hi_q  <= sh;
                state <= ST_ACK;
              end else if (idx == IDX_W'(3)) begin
                wdata_q <= {hi_q, sh};
                stb_q   <= 1'b1;
                state   <= ST_ACK;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          ST_ACK: begin
            if (ev_fall) begin
              cnt <= '0;
              if (rw_q) begin
                state   <= ST_TX;
                rd_q    <= rd_data;
                sh      <= word_byte(rd_data, 1'b0);
                lo_sent <= 1'b0;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (ev_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (ev_fall) begin
              if (cnt == CNT_W'(BYTE_W)) state <= ST_MACK;
              else                      sh <= {sh[BYTE_W-2:0], 1'b1};
            end
          end
          ST_MACK: begin
            if (ev_rise) begin
              mack_q <= ~line_s[0];
            end else if (ev_fall) begin
              if (mack_q && !lo_sent) begin
                state   <= ST_TX;
                sh      <= word_byte(rd_q, 1'b1);
                cnt     <= '0;
                lo_sent <= 1'b1;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_phase = (state == ST_ACK);
  assign rd_mode   = rw_q;
  assign sda_oe    = ack_phase | ((state == ST_TX) & ~sh[BYTE_W-1]);
  assign reg_ptr   = ptr_q;
  assign wr_stb    = stb_q;
  assign wr_data   = wdata_q;
endmodule

// File: rtl/i2c_reg16_port_chk.sv
module i2c_reg16_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] reg_ptr,
  input logic       ev_fall,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       rd_mode,
  input logic       ack_phase
);
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3

  AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(ev_fall) && !$past(rd_mode))); // R3

  AST_PTR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_ptr) |-> $past(ev_fall)); // R2

  AST_PTR_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |=> $stable(reg_ptr)); // R7

  AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !ack_phase) |-> rd_mode); // R6

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe); // R8

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe); // R9
endmodule

bind i2c_reg16_port i2c_reg16_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_stb(wr_stb),
  .reg_ptr(reg_ptr), .ev_fall(ev_fall), .ev_start(ev_start),
  .ev_stop(ev_stop), .rd_mode(rd_mode), .ack_phase(ack_phase)
);

// File: tb/i2c_reg16_port_test.sv
module i2c_reg16_port_test;
  localparam logic [6:0] DEV = 7'h45;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [7:0] reg_ptr;
  logic [15:0] wr_data, rd_data;
  logic sda_bus;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [15:0] stb_data = '0;
  logic [7:0]  stb_ptr = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [15:0] reg_val(input logic [7:0] p);
    return {p ^ 8'h5A, ~p};
  endfunction
  assign rd_data = reg_val(reg_ptr);

  i2c_reg16_port #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  always @(negedge clk)
    if (wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      stb_data <= wr_data;
      stb_ptr  <= reg_ptr;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] p, input logic [15:0] d, input string tag);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk({tag, " R1 addr ack"}, a, 1);
    send_byte(p, a);           chk({tag, " R2 ptr ack"}, a, 1);
    send_byte(d[15:8], a);     chk({tag, " R3 hi ack"}, a, 1);
    send_byte(d[7:0], a);      chk({tag, " R3 lo ack"}, a, 1);
    bus_stop();
  endtask

  task automatic do_read(output logic [15:0] w, input string tag);
    logic a;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk({tag, " R1 read addr ack"}, a, 1);
    recv_byte(w[15:8], 1'b1);
    recv_byte(w[7:0], 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, b, all_rel;
    logic [15:0] w, w2;
    logic [7:0] hb;
    int base;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 wr_stb", wr_stb, 0);
    chk("R10 reg_ptr", reg_ptr, 0);

    // R3 R6 R7: sweep over pointer patterns, write then read
    for (int k = 0; k < 8; k++) begin
      logic [7:0] p;
      logic [15:0] d;
      case (k)
        0: p = 8'h00; 1: p = 8'hFF; 2: p = 8'h01; 3: p = 8'h80;
        4: p = 8'h7F; 5: p = 8'hFE; 6: p = 8'h3C; default: p = 8'hC3;
      endcase
      d = {p ^ 8'h96, p + 8'h11};
      base = stb_cnt;
      do_write(p, d, "sweep");
      chk("R3 one strobe", stb_cnt - base, 1);
      chk("R3 wr_data hi,lo", stb_data, d);
      chk("R3 ptr at strobe", stb_ptr, p);
      do_read(w, "sweep");
      chk("R6 read word", w, reg_val(p));
      chk("R7 ptr after read", reg_ptr, p);
    end

    // R7 repeated reads without pointer write
    do_read(w, "rep1");
    do_read(w2, "rep2");
    chk("R7 repeat read equal", w2, w);
    chk("R7 repeat read value", w2, reg_val(8'hC3));

    // R2 pointer-only write
    base = stb_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R1 ack ptr-only", a, 1);
    send_byte(8'h42, a);       chk("R2 ptr-only ack", a, 1);
    bus_stop();
    chk("R2 ptr updated", reg_ptr, 8'h42);
    chk("R2 no strobe", stb_cnt - base, 0);

    // R1 foreign address
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R1 foreign nack", a, 0);
    send_byte(8'h99, a);               chk("R1 ignored byte nack", a, 0);
    send_byte(8'h12, a);               chk("R1 ignored byte2 nack", a, 0);
    send_byte(8'h34, a);               chk("R1 ignored byte3 nack", a, 0);
    bus_stop();
    chk("R1 ptr kept", reg_ptr, 8'h42);
    chk("R1 no strobe", stb_cnt - base, 0);

    // R4 truncated write after one data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a);
    send_byte(8'hAB, a); chk("R4 single data ack", a, 1);
    bus_stop();
    chk("R4 no strobe", stb_cnt - base, 0);
    chk("R4 ptr", reg_ptr, 8'h10);

    // R5 surplus byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h20, a);
    send_byte(8'hDE, a);
    send_byte(8'hAD, a);
    send_byte(8'hBE, a); chk("R5 surplus nack", a, 0);
    bus_stop();
    chk("R5 single strobe", stb_cnt - base, 1);
    chk("R5 data", stb_data, 16'hDEAD);

    // R9 pointer write, repeated start, read
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h55, a);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R9 read addr after Sr", a, 1);
    recv_byte(w[15:8], 1'b1);
    recv_byte(w[7:0], 1'b0);
    bus_stop();
    chk("R9 combined read", w, reg_val(8'h55));

    // R9 R4 start inside a write after one data byte
    base = stb_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h66, a);
    send_byte(8'h11, a);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R9 addr after Sr", a, 1);
    send_byte(8'h67, a);
    send_byte(8'hC0, a);
    send_byte(8'h1E, a);
    bus_stop();
    chk("R9 one strobe", stb_cnt - base, 1);
    chk("R9 data", stb_data, 16'hC01E);
    chk("R9 ptr", stb_ptr, 8'h67);

    // R8 NACK after high byte releases SDA
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(hb, 1'b0);
    chk("R8 hi byte", hb, reg_val(8'h67) >> 8);
    all_rel = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bit_in(b);
      all_rel = all_rel & b;
    end
    chk("R8 released after nack", all_rel, 1);
    bus_stop();
    qw();
    chk("R8 released after stop", sda_oe, 0);
    chk("R7 ptr after nack read", reg_ptr, 8'h67);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule